// File: doc/BRIEF.md
# Selectable Biquad Audio Filter

This block processes a stream of packed stereo audio samples. Each beat on the input stream carries a left and a right sample, which the block halves and adds into one mono value. That mono value feeds two fixed second-order IIR sections, one tuned as a low-pass and one as a band-pass, and it also feeds a direct bypass path. A small control register picks which of the three paths drives the output stream. Three indicator outputs, one per path, show which path is active.

Both filter sections advance on every valid input beat whatever the selected path, so a path change does not restart a section from stale history. The output stream repeats the 24-bit mono result in both halves of its 48-bit word. A beat leaves exactly two clock cycles after it enters. A single-cycle write strobe with a 2-bit value stands in for the software register bus.

Top module: `bqf_audio_top`

## Requirements
- R1: The input word carries the left sample in bits 23:0 and the right sample in bits 47:24, both signed 24-bit. The mono value is (left >>> 1) + (right >>> 1), where >>> is an arithmetic shift that rounds toward minus infinity.
- R2: In pass-through mode the output word is {mono, mono}: the mono value sits in bits 23:0 and again in bits 47:24.
- R3: `m_valid` is high exactly two clock cycles after each cycle in which `s_valid` is high, and low otherwise. `m_data` holds its last value while `m_valid` is low. Filter history changes only on valid beats.
- R4: Low-pass mode outputs a direct form I biquad y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. The Q2.14 coefficients are b0=1024, b1=2048, b2=1024, a1=−19661, a2=7373, and x is the mono value.
- R5: Band-pass mode outputs the same structure with the coefficients b0=2048, b1=0, b2=−2048, a1=−26214, a2=13107.
- R6: A write with `cfg_wr` high loads `cfg_mode`. The value 0 selects pass-through, 1 low-pass and 2 band-pass. The value 3 behaves as pass-through. The new mode takes effect from the next clock edge.
- R7: Exactly one indicator is high at all times: `lamp_pass` in pass-through (including mode 3), `lamp_low` in low-pass and `lamp_band` in band-pass.
- R8: Both sections advance on every valid beat in every mode. After a switch from bypass to a filter mode, the filter output continues from the history built up while bypass was selected.
- R9: Each section result is the accumulator plus 2^13, shifted arithmetically right by 14, and saturated to the signed 24-bit range [−8388608, 8388607]. The feedback history stores this saturated result.
- R10: A synchronous active-high reset clears all filter history and `m_valid`, sets `m_data` to zero, and selects pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input beat valid; acts as the processing enable |
| s_data | input | 48 | Packed stereo input: right in 47:24, left in 23:0 |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | Mode value written when `cfg_wr` is high |
| m_valid | output | 1 | Output beat valid |
| m_data | output | 48 | Mono result repeated in both 24-bit halves |
| lamp_pass | output | 1 | Pass-through active indicator |
| lamp_low | output | 1 | Low-pass active indicator |
| lamp_band | output | 1 | Band-pass active indicator |

## Verification
The bypass path receives positive, negative, mixed-sign and odd-valued channel pairs. These separate a correct arithmetic halving from a logical shift, from rounding toward zero, and from swapped channel fields. Impulses, steps and alternating-sign trains drive each filter and are compared beat by beat against a bench-side recursion. This tells coefficient, sign and rounding errors apart. Beats with idle gaps show whether history advances only on valid cycles. A stream that starts in bypass and then switches mode tells continuing sections from ones restarted on a mode change. Full-scale steps of both polarities drive the low-pass overshoot into the saturation limits.

// File: rtl/bqf_pkg.sv
package bqf_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int NUM_CH    = 2;
    localparam int WORD_W    = SAMPLE_W * NUM_CH;
    localparam int ACC_W     = SAMPLE_W + COEF_W + 3;
    localparam int NUM_FILT  = 2;
    localparam int LAMP_W    = 3;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_BAND = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        logic signed [COEF_W-1:0] b0;
        logic signed [COEF_W-1:0] b1;
        logic signed [COEF_W-1:0] b2;
        logic signed [COEF_W-1:0] a1;
        logic signed [COEF_W-1:0] a2;
    } coef_t;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } beat_t;

    localparam coef_t LOW_COEF = '{
        b0: 16'sd1024, b1: 16'sd2048, b2: 16'sd1024,
        a1: -16'sd19661, a2: 16'sd7373
    };

    localparam coef_t BAND_COEF = '{
        b0: 16'sd2048, b1: 16'sd0, b2: -16'sd2048,
        a1: -16'sd26214, a2: 16'sd13107
    };

    // Filter bank index order: 0 low-pass, 1 band-pass
    localparam int IDX_LOW  = 0;
    localparam int IDX_BAND = 1;

    // Round half up at the Q2.14 point, then clamp to the sample range
    function automatic sample_t round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] half_lsb;
        logic signed [ACC_W-1:0] biased;
        logic signed [ACC_W-1:0] shifted;
        logic signed [ACC_W-1:0] hi_lim;
        logic signed [ACC_W-1:0] lo_lim;
        half_lsb = $signed({{(ACC_W-COEF_FRAC){1'b0}}, 1'b1, {(COEF_FRAC-1){1'b0}}});
        hi_lim   = $signed({{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
        lo_lim   = $signed({{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});
        biased   = acc + half_lsb;
        shifted  = biased >>> COEF_FRAC;
        if (shifted > hi_lim) begin
            return hi_lim[SAMPLE_W-1:0];
        end else if (shifted < lo_lim) begin
            return lo_lim[SAMPLE_W-1:0];
        end
        return shifted[SAMPLE_W-1:0];
    endfunction

    // The reserved code falls back to bypass
    function automatic mode_e effective_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return MODE_LOW;
            2'd2:    return MODE_BAND;
            default: return MODE_PASS;
        endcase
    endfunction

    function automatic logic [LAMP_W-1:0] lamp_of(input mode_e m);
        case (m)
            MODE_LOW:  return 3'b010;
            MODE_BAND: return 3'b100;
            default:   return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/bqf_mixer.sv
module bqf_mixer
    import bqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output beat_t             mono
);

    sample_t halves [NUM_CH];
    sample_t sum;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_half
        assign halves[ch] = $signed(in_data[ch*SAMPLE_W +: SAMPLE_W]) >>> 1;
    end

    always_comb begin
        sum = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            sum = sum + halves[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mono <= '0;
        end else begin
            mono.valid <= in_valid;
            if (in_valid) begin
                mono.data <= sum;
            end
        end
    end

    // R3
    mix_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> mono.valid);

endmodule

// File: rtl/bqf_biquad.sv
module bqf_biquad
    import bqf_pkg::*;
#(
    parameter coef_t COEF = LOW_COEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t x,
    output sample_t y
);

    sample_t x1, x2, y1, y2;

    logic signed [ACC_W-1:0] p_b0, p_b1, p_b2, p_a1, p_a2;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        p_b0 = ACC_W'(x)  * ACC_W'(COEF.b0);
        p_b1 = ACC_W'(x1) * ACC_W'(COEF.b1);
        p_b2 = ACC_W'(x2) * ACC_W'(COEF.b2);
        p_a1 = ACC_W'(y1) * ACC_W'(COEF.a1);
        p_a2 = ACC_W'(y2) * ACC_W'(COEF.a2);
        acc  = p_b0 + p_b1 + p_b2 - p_a1 - p_a2;
        y    = round_sat(acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x1 <= '0;
            x2 <= '0;
            y1 <= '0;
            y2 <= '0;
        end else if (en) begin
            x1 <= x;
            x2 <= x1;
            y1 <= y;
            y2 <= y1;
        end
    end

    // R3
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(x1) && $stable(x2) && $stable(y1) && $stable(y2)));

    // R8
    shift_line_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (x2 == $past(x1) && y2 == $past(y1)));

endmodule

// File: rtl/bqf_mode_reg.sv
module bqf_mode_reg
    import bqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    output mode_e             mode,
    output logic [LAMP_W-1:0] lamps
);

    logic [1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 2'd0;
        end else if (wr_en) begin
            raw_q <= wr_mode;
        end
    end

    assign mode  = effective_mode(raw_q);
    assign lamps = lamp_of(mode);

    // R7
    one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps) == 1);

    // R6
    rsvd_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd3) |=> (lamps == 3'b001));

endmodule

// File: rtl/bqf_audio_top.sv
module bqf_audio_top
    import bqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    output logic              m_valid,
    output logic [WORD_W-1:0] m_data,
    output logic              lamp_pass,
    output logic              lamp_low,
    output logic              lamp_band
);

    localparam coef_t BANK [NUM_FILT] = '{LOW_COEF, BAND_COEF};

    beat_t             mono;
    sample_t           filt_y [NUM_FILT];
    sample_t           chosen;
    mode_e             mode;
    logic [LAMP_W-1:0] lamps;

    bqf_mixer u_mixer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_valid),
        .in_data  (s_data),
        .mono     (mono)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        bqf_biquad #(.COEF(BANK[f])) u_bq (
            .clk (clk),
            .rst (rst),
            .en  (mono.valid),
            .x   (mono.data),
            .y   (filt_y[f])
        );
    end

    bqf_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_mode (cfg_mode),
        .mode    (mode),
        .lamps   (lamps)
    );

    always_comb begin
        case (mode)
            MODE_LOW:  chosen = filt_y[IDX_LOW];
            MODE_BAND: chosen = filt_y[IDX_BAND];
            default:   chosen = mono.data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= mono.valid;
            if (mono.valid) begin
                m_data <= {NUM_CH{chosen}};
            end
        end
    end

    assign lamp_pass = lamps[0];
    assign lamp_low  = lamps[1];
    assign lamp_band = lamps[2];

    // R3
    out_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mono.valid |=> m_valid);

    // R3
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mono.valid |=> (!m_valid && $stable(m_data)));

    // R2
    bypass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (mono.valid && mode == MODE_PASS) |=> (m_data[SAMPLE_W-1:0] == $past(mono.data)));

endmodule

// File: tb/bqf_audio_top_tb.sv
module bqf_audio_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic [47:0] s_data = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        m_valid;
    logic [47:0] m_data;
    logic        lamp_pass, lamp_low, lamp_band;

    int checks = 0;
    int fails  = 0;
    string req = "R10";

    // model: filter bank 0 low, 1 band
    longint cf [2][5] = '{'{1024, 2048, 1024, -19661, 7373},
                          '{2048, 0, -2048, -26214, 13107}};
    longint st [2][4];          // x1, x2, y1, y2
    int     cur_mode = 0;       // 0 pass, 1 low, 2 band
    bit     p1_v = 0, p2_v = 0;
    longint p1_d = 0, p2_d = 0;
    longint last_out = 0;

    bqf_audio_top u_dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .m_valid(m_valid), .m_data(m_data),
        .lamp_pass(lamp_pass), .lamp_low(lamp_low), .lamp_band(lamp_band)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input string r, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic longint sx24(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint mono_of(input longint l, input longint r);
        return (l >>> 1) + (r >>> 1);
    endfunction

    function automatic longint step_filter(input int f, input longint x);
        longint acc, y;
        acc = cf[f][0]*x + cf[f][1]*st[f][0] + cf[f][2]*st[f][1]
            - cf[f][3]*st[f][2] - cf[f][4]*st[f][3];
        y = (acc + 8192) >>> 14;
        if (y > 8388607) y = 8388607;
        if (y < -8388608) y = -8388608;
        st[f][1] = st[f][0]; st[f][0] = x;
        st[f][3] = st[f][2]; st[f][2] = y;
        return y;
    endfunction

    function automatic void clear_model();
        for (int f = 0; f < 2; f++) for (int k = 0; k < 4; k++) st[f][k] = 0;
        p1_v = 0; p2_v = 0; p1_d = 0; p2_d = 0; last_out = 0; cur_mode = 0;
    endfunction

    // One clock: check what left two cycles ago, then drive a new beat
    task automatic cycle(input bit v, input longint l, input longint r);
        longint m, yl, yb, o;
        @(negedge clk);
        check({req, " R3 valid"}, longint'(m_valid), longint'(p2_v));
        if (p2_v) last_out = p2_d;
        check({req, " lo half"}, sx24(m_data[23:0]), last_out);
        check({req, " R2 hi half"}, sx24(m_data[47:24]), last_out);
        p2_v = p1_v; p2_d = p1_d;
        s_valid = v;
        s_data  = {r[23:0], l[23:0]};
        p1_v = v;
        if (v) begin
            m  = mono_of(sx24(l[23:0]), sx24(r[23:0]));
            yl = step_filter(0, m);
            yb = step_filter(1, m);
            o  = (cur_mode == 1) ? yl : (cur_mode == 2) ? yb : m;
            p1_d = o;
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) cycle(0, 0, 0);
    endtask

    task automatic check_lamps(input string r, input int m);
        check({r, " lamp_pass"}, longint'(lamp_pass), longint'(m == 0));
        check({r, " lamp_low"},  longint'(lamp_low),  longint'(m == 1));
        check({r, " lamp_band"}, longint'(lamp_band), longint'(m == 2));
    endtask

    task automatic set_mode(input logic [1:0] code);
        flush();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = code; s_valid = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_mode = (code == 2'd3) ? 0 : int'(code);
        check("R7 R6 mode write", longint'({lamp_band, lamp_low, lamp_pass}),
              (cur_mode == 1) ? 2 : (cur_mode == 2) ? 4 : 1);
        check_lamps("R7", cur_mode);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; s_valid = 1'b0; cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        check("R10 m_valid", longint'(m_valid), 0);
        check("R10 m_data", longint'(m_data), 0);
        check_lamps("R10", 0);
    endtask

    task automatic test_reset();
        req = "R10";
        do_reset();
    endtask

    task automatic test_bypass();
        req = "R1";
        cycle(1, 1000, 2000);
        cycle(1, -1000, -3000);
        cycle(1, 3, 5);
        cycle(1, -3, -5);
        cycle(1, 8388607, -8388608);
        cycle(1, -8388608, -8388608);
        cycle(1, 8388607, 8388607);
        cycle(1, 12345, 0);
        cycle(1, 0, 12345);
        flush();
    endtask

    task automatic test_gaps();
        req = "R3";
        cycle(1, 400, 800);
        cycle(0, 999, 999);
        cycle(0, 77, 77);
        cycle(1, -600, 100);
        cycle(1, 50, 50);
        cycle(0, 5, 5);
        cycle(1, 7, 9);
        flush();
    endtask

    task automatic test_lowpass();
        set_mode(2'd1);
        req = "R4";
        cycle(1, 200000, 200000);
        for (int i = 0; i < 10; i++) cycle(1, 0, 0);
        for (int i = 0; i < 12; i++) cycle(1, 100000, 60000);
        for (int i = 0; i < 6; i++) begin
            cycle(1, 30001, 30001);
            cycle(0, 0, 0);
        end
        flush();
    endtask

    task automatic test_bandpass();
        set_mode(2'd2);
        req = "R5";
        cycle(1, 400000, 400000);
        for (int i = 0; i < 10; i++) cycle(1, 0, 0);
        for (int i = 0; i < 16; i++) cycle(1, (i % 2) ? -250001 : 250001, 3);
        flush();
    endtask

    task automatic test_reserved();
        set_mode(2'd3);
        req = "R6";
        cycle(1, 11111, -2222);
        cycle(1, -5, 7);
        flush();
        set_mode(2'd0);
        cycle(1, 64, 32);
        flush();
    endtask

    task automatic test_continuity();
        req = "R8";
        set_mode(2'd0);
        for (int i = 0; i < 5; i++) cycle(1, 300000 - i*70000, 150000);
        set_mode(2'd1);
        req = "R8";
        for (int i = 0; i < 4; i++) cycle(1, 0, 0);
        set_mode(2'd2);
        req = "R8";
        for (int i = 0; i < 4; i++) cycle(1, -20000, 0);
        flush();
    endtask

    task automatic test_saturate();
        do_reset();
        set_mode(2'd1);
        req = "R9";
        for (int i = 0; i < 14; i++) cycle(1, 8388607, 8388607);
        for (int i = 0; i < 14; i++) cycle(1, -8388608, -8388608);
        flush();
    endtask

    task automatic test_reset_midrun();
        set_mode(2'd2);
        req = "R10";
        for (int i = 0; i < 6; i++) cycle(1, 500000, -100000);
        do_reset();
        set_mode(2'd2);
        req = "R10";
        cycle(1, 80000, 80000);
        for (int i = 0; i < 5; i++) cycle(1, 0, 0);
        flush();
    endtask

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 initial m_valid", longint'(m_valid), 0);
        check_lamps("R10 initial", 0);
        test_reset();
        test_bypass();
        test_gaps();
        test_lowpass();
        test_bandpass();
        test_reserved();
        test_continuity();
        test_saturate();
        test_reset_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule